// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block holds the row map of a memory controller that drives four DRAM rows, and it names the row that a memory request falls in. Software programs one byte per row through a byte-addressed configuration port. Each byte is a running total: the byte for row N gives the memory held in rows 0 through N, counted in 32 MB units. A row's lower edge is therefore the byte of the row below it, and row 0 starts at zero. A row whose byte equals the byte below it is empty.

On each clock, the decoder takes bits 32:25 of a request address and compares them with the four boundaries. It returns a one-hot row select for the lowest-numbered row whose boundary lies strictly above those bits. If no row's boundary lies above them, it raises an out-of-range flag instead. All memory is sized in 64 MB steps, so the lowest bit of every boundary byte is always stored as zero. The configuration space also holds a read-only capabilities pointer that always reads zero, which marks an empty capability list. The bytes above the four implemented rows are reserved. They read as zero and ignore writes.

Top module: `dram_row_map`

## Requirements
- R1: While `rst` is high, and for one cycle after the first clock edge that sees it, `row_sel`, `out_of_range` and `cfg_rdata` are zero. All four boundary bytes clear to 00h.
- R2: A write with `cfg_wr_en` high to offset 40h+N (N = 0..3) stores `cfg_wdata` into the boundary of row N with bit 0 forced to zero. A later read of 40h+N returns the stored value.
- R3: Offsets 44h to 4Fh always read 00h. Writes to them change no boundary byte and no decode result.
- R4: Offset 34h always reads 00h. A write to it has no effect.
- R5: One cycle after `req_addr` is presented, `row_sel` has exactly bit N set. N is the lowest row whose boundary is strictly greater than `req_addr`, taken as an unsigned 8-bit value.
- R6: A row whose boundary equals the boundary of the row below it is never selected. If row 0 has boundary 00h, row 0 is never selected.
- R7: When `req_addr` is greater than or equal to the row 3 boundary, `out_of_range` is 1 one cycle later and `row_sel` is 0000. With all boundaries at 00h, every address is out of range.
- R8: After reset, exactly one of the five signals made up of the `row_sel` bits and `out_of_range` is high on every cycle.
- R9: `cfg_rdata` is registered. It shows, one cycle later, the byte at the offset that `cfg_addr` held at the clock edge, and it uses the value from before any write on that same edge. Offsets outside 34h and 40h..4Fh read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr | input | 8 | Configuration byte offset for reads and writes |
| cfg_wr_en | input | 1 | Write strobe for the byte at `cfg_addr` |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data for the byte at `cfg_addr` |
| req_addr | input | 8 | Request address bits 32:25 (32 MB granules) |
| row_sel | output | 4 | Registered one-hot row select, bit N for row N |
| out_of_range | output | 1 | Registered flag: the address lies beyond all populated rows |

## Verification
The bench sweeps the address field across every row edge. A decoder that compared with `>=` instead of `>` would move each edge address into the row below it, and a wrong priority order would pick a higher row when two boundaries overlap. It sets up empty rows, both in the middle of the map and at row 0. A design that did not skip empty rows would select an empty row for the address at its edge. It writes odd values and fills the reserved window and the pointer offset with ones. Each of these then shows up as a readback with bit 0 set or a non-zero reserved byte. It also checks the top of the 8-bit range and a read issued on the same edge as a write, so an off-by-one at FEh or a read that passes the write through shows up as a mismatch.

// File: rtl/dram_row_pkg.sv
package dram_row_pkg;
  localparam int BND_W       = 8;                 // boundary byte width
  localparam int ROW_SLOTS   = 16;                // offsets set aside for rows
  localparam logic [BND_W-1:0] CAP_PTR_VAL = '0;  // empty capability list
  typedef logic [BND_W-1:0] bnd_t;
endpackage

// File: rtl/dram_row_regs.sv
module dram_row_regs
  import dram_row_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int CFG_AW   = 8,
  parameter int BND_BASE = 'h40,
  parameter int CAP_OFS  = 'h34
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [CFG_AW-1:0]         addr,
  input  bnd_t                      wdata,
  output logic [NUM_ROWS*BND_W-1:0] bnd_flat,
  output bnd_t                      rd_val
);
  bnd_t bnd_q [NUM_ROWS];

  // Boundary bytes; bit 0 is dropped so every row stays on a 64 MB step.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ROWS; i++) bnd_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_ROWS; i++) begin
        if (addr == CFG_AW'(BND_BASE + i)) bnd_q[i] <= {wdata[BND_W-1:1], 1'b0};
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_ROWS; g++) begin : g_flat
      assign bnd_flat[g*BND_W +: BND_W] = bnd_q[g];
    end
  endgenerate

  // Read mux: reserved slots and unknown offsets fall through to zero.
  always_comb begin
    rd_val = '0;
    if (addr == CFG_AW'(CAP_OFS)) rd_val = CAP_PTR_VAL;
    for (int i = 0; i < NUM_ROWS; i++) begin
      if (addr == CFG_AW'(BND_BASE + i)) rd_val = bnd_q[i];
    end
  end
endmodule

// File: rtl/dram_row_lookup.sv
module dram_row_lookup
  import dram_row_pkg::*;
#(
  parameter int NUM_ROWS = 4
) (
  input  bnd_t                      field,
  input  logic [NUM_ROWS*BND_W-1:0] bnd_flat,
  output logic [NUM_ROWS-1:0]       sel,
  output logic                      oor
);
  logic [NUM_ROWS-1:0] above;

  genvar g;
  generate
    for (g = 0; g < NUM_ROWS; g++) begin : g_cmp
      assign above[g] = bnd_flat[g*BND_W +: BND_W] > field;
    end
  endgenerate

  // Lowest row whose limit exceeds the field wins; empty rows lose to the
  // row below, which shares their limit.
  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    oor   = ~above[NUM_ROWS-1];
    for (int i = 0; i < NUM_ROWS; i++) begin
      if (above[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
    if (oor) sel = '0;
  end
endmodule

// File: rtl/dram_row_map.sv
module dram_row_map
  import dram_row_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int CFG_AW   = 8,
  parameter int BND_BASE = 'h40,
  parameter int CAP_OFS  = 'h34,
  parameter int UNIT_LSB = 25
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic                          cfg_wr_en,
  input  logic [BND_W-1:0]              cfg_wdata,
  output logic [BND_W-1:0]              cfg_rdata,
  input  logic [UNIT_LSB+BND_W-1:UNIT_LSB] req_addr,
  output logic [NUM_ROWS-1:0]           row_sel,
  output logic                          out_of_range
);
  logic [NUM_ROWS*BND_W-1:0] bnd_flat;
  bnd_t                      rd_val;
  logic [NUM_ROWS-1:0]       sel_c;
  logic                      oor_c;

  dram_row_regs #(
    .NUM_ROWS(NUM_ROWS), .CFG_AW(CFG_AW), .BND_BASE(BND_BASE), .CAP_OFS(CAP_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr), .wdata(cfg_wdata),
    .bnd_flat(bnd_flat), .rd_val(rd_val)
  );

  dram_row_lookup #(.NUM_ROWS(NUM_ROWS)) u_lookup (
    .field(req_addr), .bnd_flat(bnd_flat), .sel(sel_c), .oor(oor_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata    <= '0;
      row_sel      <= '0;
      out_of_range <= 1'b0;
    end else begin
      cfg_rdata    <= rd_val;
      row_sel      <= sel_c;
      out_of_range <= oor_c;
    end
  end
endmodule

// File: rtl/dram_row_map_chk.sv
module dram_row_map_chk
  import dram_row_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int CFG_AW   = 8,
  parameter int BND_BASE = 'h40,
  parameter int CAP_OFS  = 'h34
) (
  input logic                      clk,
  input logic                      rst,
  input logic [CFG_AW-1:0]         cfg_addr,
  input logic [BND_W-1:0]          cfg_rdata,
  input logic [BND_W-1:0]          req_addr,
  input logic [NUM_ROWS-1:0]       row_sel,
  input logic                      out_of_range,
  input logic [NUM_ROWS*BND_W-1:0] bnd_flat
);
  logic live;
  bnd_t bnd [NUM_ROWS];

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_ROWS; g++) begin : g_unpack
      assign bnd[g] = bnd_flat[g*BND_W +: BND_W];
    end
  endgenerate

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (row_sel == '0 && !out_of_range && cfg_rdata == '0));

  assert_bit0_clear_R2: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(cfg_addr) >= CFG_AW'(BND_BASE) && $past(cfg_addr) < CFG_AW'(BND_BASE + NUM_ROWS))
    |-> cfg_rdata[0] == 1'b0);

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(cfg_addr) >= CFG_AW'(BND_BASE + NUM_ROWS) &&
     $past(cfg_addr) <= CFG_AW'(BND_BASE + ROW_SLOTS - 1)) |-> cfg_rdata == '0);

  assert_cap_zero_R4: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(cfg_addr) == CFG_AW'(CAP_OFS)) |-> cfg_rdata == '0);

  generate
    for (g = 0; g < NUM_ROWS; g++) begin : g_row
      assert_sel_above_R5: assert property (@(posedge clk) disable iff (rst || !live)
        row_sel[g] |-> $past(bnd[g]) > $past(req_addr));
      if (g > 0) begin : g_upper
        assert_sel_lowest_R5: assert property (@(posedge clk) disable iff (rst || !live)
          row_sel[g] |-> $past(bnd[g-1]) <= $past(req_addr));
        assert_no_empty_R6: assert property (@(posedge clk) disable iff (rst || !live)
          row_sel[g] |-> $past(bnd[g]) != $past(bnd[g-1]));
      end else begin : g_first
        assert_row0_empty_R6: assert property (@(posedge clk) disable iff (rst || !live)
          row_sel[0] |-> $past(bnd[0]) != '0);
      end
    end
  endgenerate

  assert_oor_flag_R7: assert property (@(posedge clk) disable iff (rst || !live)
    out_of_range == ($past(req_addr) >= $past(bnd[NUM_ROWS-1])));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst || !live)
    $countones({row_sel, out_of_range}) == 1);
endmodule

bind dram_row_map dram_row_map_chk #(
  .NUM_ROWS(NUM_ROWS), .CFG_AW(CFG_AW), .BND_BASE(BND_BASE), .CAP_OFS(CAP_OFS)
) u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .req_addr(req_addr), .row_sel(row_sel), .out_of_range(out_of_range),
  .bnd_flat(bnd_flat)
);

// File: tb/dram_row_map_bench.sv
`timescale 1ns/1ps
module dram_row_map_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_addr = '0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [7:0] req_addr = '0;
  logic [3:0] row_sel;
  logic       out_of_range;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dram_row_map u_dram_row_map (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
    .row_sel(row_sel), .out_of_range(out_of_range)
  );

  // Behavioural reference: running totals and expected registered outputs.
  int         m_bnd [4];
  logic [3:0] e_sel = '0;
  logic       e_oor = 1'b0;
  logic [7:0] e_rd  = '0;
  int         m_a, m_f;
  bit         m_hit;

  always @(posedge clk) begin
    if (rst) begin
      e_sel = '0; e_oor = 1'b0; e_rd = '0;
      for (int r = 0; r < 4; r++) m_bnd[r] = 0;
    end else begin
      m_a = int'(cfg_addr);
      m_f = int'(req_addr);
      e_rd = (m_a >= 'h40 && m_a <= 'h43) ? 8'(m_bnd[m_a - 'h40]) : 8'h00;
      e_oor = (m_f >= m_bnd[3]);
      e_sel = '0;
      m_hit = 1'b0;
      if (!e_oor) begin
        for (int r = 0; r < 4; r++) begin
          if (!m_hit && m_bnd[r] > m_f) begin e_sel[r] = 1'b1; m_hit = 1'b1; end
        end
      end
      if (cfg_wr_en && m_a >= 'h40 && m_a <= 'h43)
        m_bnd[m_a - 'h40] = int'(cfg_wdata) & 'hFE;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: drive after the falling edge, compare at the next falling edge.
  task automatic step(input logic [7:0] a, input logic we, input logic [7:0] d,
                      input logic [7:0] fld, input string tag);
    cfg_addr = a; cfg_wr_en = we; cfg_wdata = d; req_addr = fld;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "cfg_rdata", int'(cfg_rdata), int'(e_rd));
    chk(tag, "row_sel", int'(row_sel), int'(e_sel));
    chk(tag, "out_of_range", int'(out_of_range), int'(e_oor));
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    step(a, 1'b1, d, 8'h00, tag);
  endtask

  task automatic rd_expect(input logic [7:0] a, input int exp, input string tag);
    step(a, 1'b0, 8'h00, 8'h00, tag);
    chk(tag, "readback", int'(cfg_rdata), exp);
  endtask

  task automatic dec_expect(input logic [7:0] fld, input int sel, input int oor, input string tag);
    step(8'h00, 1'b0, 8'h00, fld, tag);
    chk(tag, "row_sel fixed", int'(row_sel), sel);
    chk(tag, "oor fixed", int'(out_of_range), oor);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1: reset holds everything at zero even with a write pending
    step(8'h40, 1'b1, 8'hFF, 8'h00, "R1");
    step(8'h40, 1'b1, 8'hFF, 8'h10, "R1");
    chk("R1", "row_sel in reset", int'(row_sel), 0);
    chk("R1", "oor in reset", int'(out_of_range), 0);
    rst = 1'b0;
    for (int a = 'h40; a <= 'h43; a++) rd_expect(8'(a), 0, "R1");
    // R7: empty map, everything beyond memory
    dec_expect(8'h00, 0, 1, "R7");
    dec_expect(8'h80, 0, 1, "R7");

    // R2: program rows 2,4(empty third row),4 ... odd values lose bit 0
    wr(8'h40, 8'h03, "R2");
    wr(8'h41, 8'h06, "R2");
    wr(8'h42, 8'h06, "R2");
    wr(8'h43, 8'h0B, "R2");
    rd_expect(8'h40, 'h02, "R2");
    rd_expect(8'h41, 'h06, "R2");
    rd_expect(8'h42, 'h06, "R2");
    rd_expect(8'h43, 'h0A, "R2");

    // R5 / R7: sweep across every edge
    for (int f = 0; f < 16; f++) step(8'h00, 1'b0, 8'h00, 8'(f), (f < 10) ? "R5" : "R7");
    dec_expect(8'h01, 'b0001, 0, "R5");
    dec_expect(8'h02, 'b0010, 0, "R5");
    dec_expect(8'h05, 'b0010, 0, "R6");
    dec_expect(8'h06, 'b1000, 0, "R6");
    dec_expect(8'h09, 'b1000, 0, "R5");
    dec_expect(8'h0A, 'b0000, 1, "R7");

    // R3: reserved window reads zero and ignores writes
    for (int a = 'h44; a <= 'h4F; a++) wr(8'(a), 8'hFF, "R3");
    for (int a = 'h44; a <= 'h4F; a++) rd_expect(8'(a), 0, "R3");
    rd_expect(8'h43, 'h0A, "R3");
    dec_expect(8'h0A, 'b0000, 1, "R3");

    // R4: capabilities pointer
    wr(8'h34, 8'hAA, "R4");
    rd_expect(8'h34, 0, "R4");
    dec_expect(8'h00, 'b0001, 0, "R4");

    // R9: read on the same edge as a write returns the old byte
    step(8'h41, 1'b1, 8'h10, 8'h00, "R9");
    chk("R9", "read-old", int'(cfg_rdata), 'h06);
    rd_expect(8'h41, 'h10, "R9");
    rd_expect(8'h20, 0, "R9");

    // R6: empty row 0, full 8-bit range at the top
    wr(8'h40, 8'h00, "R6");
    wr(8'h41, 8'h05, "R2");
    wr(8'h42, 8'h08, "R6");
    wr(8'h43, 8'hFE, "R7");
    rd_expect(8'h41, 'h04, "R2");
    dec_expect(8'h00, 'b0010, 0, "R6");
    dec_expect(8'h03, 'b0010, 0, "R6");
    dec_expect(8'h04, 'b0100, 0, "R5");
    dec_expect(8'h08, 'b1000, 0, "R5");
    dec_expect(8'hFD, 'b1000, 0, "R7");
    dec_expect(8'hFE, 'b0000, 1, "R7");
    dec_expect(8'hFF, 'b0000, 1, "R7");

    // R8: one of the five outputs on every cycle over a sweep
    for (int f = 0; f < 256; f += 7) begin
      step(8'h00, 1'b0, 8'h00, 8'(f), "R8");
      chk("R8", "exclusive", $countones({row_sel, out_of_range}), 1);
    end
    finish_run();
  end
endmodule